// File: doc/BRIEF.md
# Packed Instruction Store with Parity

This block is the program memory of a small processor whose instructions are 13 bits wide. Instead of spending a full memory word on each instruction, it keeps two instructions in one 27-bit row. The row is cut into three 9-bit slices, and each slice sits in its own bank. The one bit left over in each row holds an even-parity check over the two instructions. The banks are read in parallel, so a whole row comes back in one access.

The processor drives its program counter on `rd_pc`. The upper counter bits pick the row, and the lowest bit picks the instruction inside it. One clock later the chosen instruction appears on `instr`, and `parity_err` reports whether the row that was read is consistent.

A write port loads one row at a time and generates the parity bit itself. The top bit of the written row is not stored as is: it is XORed into the generated parity. Driving it high stores a deliberately wrong parity bit, which gives a way to place a corrupted row through the normal write path.

Top module: `packed_irom`

## Requirements
- R1: The row address is `rd_pc[PC_W-1:1]`. When `rd_pc[0]` is 0 the output is row bits 12:0. When it is 1 the output is row bits 25:13. In both cases these are the bits written as `wr_row[12:0]` and `wr_row[25:13]`.
- R2: Reads are synchronous. The instruction for the `rd_pc` sampled at one rising edge is on `instr` from that edge until the next one, so an address that changes every cycle yields a new instruction every cycle.
- R3: When a row is written with `wr_row[26]` = 0, the block stores a parity bit that makes the 27 stored bits even. Reading either half of that row gives `parity_err` = 0.
- R4: When a row is written with `wr_row[26]` = 1, the block stores the inverted parity bit. Reading either half of that row gives `parity_err` = 1.
- R5: `parity_err` belongs to the row that `instr` comes from. It changes in the same cycle as `instr`, with no added delay.
- R6: A row written at an edge while the same row is being read returns the new contents in the following cycle.
- R7: While `rst_n` is low, the read address register holds 0, so `instr` shows the low half of row 0. Rows can be written while reset is active.
- R8: A write changes only the addressed row. All other rows keep their contents and their parity state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with `clk` |
| rd_pc | input | PC_W (11) | Program counter; upper bits give the row, bit 0 gives the half |
| instr | output | INSTR_W (13) | Instruction read for the previous cycle's `rd_pc` |
| parity_err | output | 1 | High when the row behind `instr` fails the even-parity check |
| wr_en | input | 1 | Writes `wr_row` into row `wr_row_addr` at the rising edge |
| wr_row_addr | input | PC_W-1 (10) | Row address for the write port |
| wr_row | input | 2*INSTR_W+1 (27) | Bits 25:0 carry the two instructions; bit 26 set inverts the stored parity |

## Verification
The hardest case to reach from the ports is a row whose stored parity disagrees with its data. A correct write never produces one. The bench creates such rows with the parity-inversion bit on the write port, and it does so both during the initial load and later at run time. It then reads both halves of these rows alongside clean neighbours.

A second case is a write that lands on the very row being read in the same cycle. The bench pairs each such write with a read address that points at the same row. This exercises the write-first path one cycle later.

// File: rtl/packed_irom_pkg.sv
package packed_irom_pkg;

  // Even parity over a 26-bit pair of instructions
  function automatic logic pair_parity(input logic [25:0] pair);
    return ^pair;
  endfunction

endpackage

// File: rtl/irom_bank.sv
module irom_bank #(
  parameter int W  = 9,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] raddr_q;
  logic [AW-1:0] raddr_d;

  always_comb raddr_d = raddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raddr_q <= '0;
    else        raddr_q <= raddr_d;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr_q];

  // R6
  bank_wr_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(we) && ($past(waddr) == $past(raddr))) |-> (rdata == $past(wdata)));

endmodule

// File: rtl/irom_row_encode.sv
module irom_row_encode #(
  parameter int INSTR_W = 13
) (
  input  logic [2*INSTR_W-1:0] pair,
  input  logic                 flip,
  output logic [2*INSTR_W:0]   row
);
  always_comb begin
    row = {(^pair) ^ flip, pair};
  end
endmodule

// File: rtl/irom_row_decode.sv
module irom_row_decode #(
  parameter int INSTR_W = 13
) (
  input  logic [2*INSTR_W:0]   row,
  input  logic                 hi_sel,
  output logic [INSTR_W-1:0]   instr,
  output logic                 bad
);
  always_comb begin
    instr = hi_sel ? row[2*INSTR_W-1:INSTR_W] : row[INSTR_W-1:0];
    bad   = ^row;
  end
endmodule

// File: rtl/packed_irom.sv
module packed_irom #(
  parameter int INSTR_W = 13,
  parameter int PC_W    = 11,
  parameter int BANK_W  = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PC_W-1:0]      rd_pc,
  output logic [INSTR_W-1:0]   instr,
  output logic                 parity_err,
  input  logic                 wr_en,
  input  logic [PC_W-2:0]      wr_row_addr,
  input  logic [2*INSTR_W:0]   wr_row
);
  localparam int ROW_W  = 2 * INSTR_W + 1;
  localparam int NBANK  = (ROW_W + BANK_W - 1) / BANK_W;
  localparam int SPAN_W = NBANK * BANK_W;
  localparam int ROW_AW = PC_W - 1;

  logic [ROW_W-1:0]  enc_row;
  logic [SPAN_W-1:0] wr_span;
  logic [SPAN_W-1:0] rd_span;
  logic [ROW_W-1:0]  rd_row;
  logic              sel_q;
  logic              sel_d;

  irom_row_encode #(.INSTR_W(INSTR_W)) u_enc (
    .pair (wr_row[2*INSTR_W-1:0]),
    .flip (wr_row[ROW_W-1]),
    .row  (enc_row)
  );

  always_comb begin
    wr_span = '0;
    wr_span[ROW_W-1:0] = enc_row;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    irom_bank #(.W(BANK_W), .AW(ROW_AW)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en),
      .waddr (wr_row_addr),
      .wdata (wr_span[b*BANK_W +: BANK_W]),
      .raddr (rd_pc[PC_W-1:1]),
      .rdata (rd_span[b*BANK_W +: BANK_W])
    );
  end

  assign rd_row = rd_span[ROW_W-1:0];

  always_comb sel_d = rd_pc[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_d;
  end

  irom_row_decode #(.INSTR_W(INSTR_W)) u_dec (
    .row    (rd_row),
    .hi_sel (sel_q),
    .instr  (instr),
    .bad    (parity_err)
  );

  // R3
  par_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && ($past(wr_row_addr) == $past(rd_pc[PC_W-1:1]))
     && !$past(wr_row[ROW_W-1])) |-> !parity_err);

  // R4
  par_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && ($past(wr_row_addr) == $past(rd_pc[PC_W-1:1]))
     && $past(wr_row[ROW_W-1])) |-> parity_err);

  // R1
  half_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && ($past(wr_row_addr) == $past(rd_pc[PC_W-1:1])))
    |-> (instr == ($past(rd_pc[0]) ? $past(wr_row[2*INSTR_W-1:INSTR_W])
                                   : $past(wr_row[INSTR_W-1:0]))));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_en) && $stable(rd_pc) && $past(rd_pc) == rd_pc && !wr_en)
    |=> $stable(instr));

endmodule

// File: tb/packed_irom_test.sv
module packed_irom_test;
  localparam int IW = 13;
  localparam int PW = 11;
  localparam int RA = PW - 1;
  localparam int NROW = 1 << RA;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] rd_pc = '0;
  logic [IW-1:0] instr;
  logic          parity_err;
  logic          wr_en = 1'b0;
  logic [RA-1:0] wr_row_addr = '0;
  logic [2*IW:0] wr_row = '0;

  packed_irom uut (
    .clk(clk), .rst_n(rst_n), .rd_pc(rd_pc), .instr(instr),
    .parity_err(parity_err), .wr_en(wr_en), .wr_row_addr(wr_row_addr),
    .wr_row(wr_row)
  );

  always #2 clk = ~clk;

  // Reference: plain arrays of pairs and flip flags
  logic [2*IW-1:0] m_pair [NROW];
  logic            m_flip [NROW];
  int              m_pc;
  bit              m_same;
  bit              chk_en = 0;
  string           phase = "R7";
  int              checks = 0;
  int              errors = 0;

  always @(posedge clk) begin
    m_same = wr_en && (int'(wr_row_addr) == (rst_n ? int'(rd_pc) >> 1 : 0));
    if (wr_en) begin
      m_pair[wr_row_addr] = wr_row[2*IW-1:0];
      m_flip[wr_row_addr] = wr_row[2*IW];
    end
    m_pc = rst_n ? int'(rd_pc) : 0;
  end

  always @(negedge clk) begin
    if (chk_en) begin
      logic [IW-1:0] e_i;
      logic          e_p;
      string         tg;
      e_i = (m_pc % 2 == 1) ? m_pair[m_pc >> 1][2*IW-1:IW] : m_pair[m_pc >> 1][IW-1:0];
      e_p = m_flip[m_pc >> 1];
      tg  = !rst_n ? "R7" : (m_same ? "R6" : phase);
      checks++;
      if (instr !== e_i) begin
        errors++;
        $display("FAIL %s instr pc=%0d actual=%h expected=%h", tg, m_pc, instr, e_i);
      end
      checks++;
      if (parity_err !== e_p) begin
        errors++;
        $display("FAIL %s parity_err (R5 R3 R4) pc=%0d actual=%b expected=%b",
                 tg, m_pc, parity_err, e_p);
      end
    end
  end

  task automatic put_row(input int r, input bit flip);
    wr_en       = 1'b1;
    wr_row_addr = RA'(r);
    wr_row      = {flip, 26'($urandom)};
  endtask

  initial begin
    // R7: load every row while reset is held
    for (int r = 0; r < NROW; r++) begin
      put_row(r, (r % 37) == 5);
      @(negedge clk);
    end
    wr_en = 1'b0;
    chk_en = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 R2: sequential sweep over every instruction
    phase = "R1";
    for (int p = 0; p < 2 * NROW; p++) begin
      rd_pc = PW'(p);
      @(negedge clk);
    end
    // R2: random addresses each cycle
    phase = "R2";
    for (int k = 0; k < 1500; k++) begin
      rd_pc = PW'($urandom);
      @(negedge clk);
    end
    // R6: write and read the same row in one cycle
    for (int k = 0; k < 200; k++) begin
      int r;
      r = int'($urandom % NROW);
      put_row(r, k % 3 == 0);
      rd_pc = PW'(r * 2 + (k % 2));
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
    end
    // R4 R3: rewrite a block of rows with mixed parity, read both halves
    phase = "R4";
    for (int r = 100; r < 140; r++) begin
      put_row(r, r % 2 == 1);
      @(negedge clk);
    end
    wr_en = 1'b0;
    for (int p = 200; p < 280; p++) begin
      rd_pc = PW'(p);
      @(negedge clk);
    end
    // R8: writes to rows other than the one read, then a full sweep
    phase = "R8";
    for (int k = 0; k < 300; k++) begin
      int r;
      r = int'($urandom % NROW);
      rd_pc = PW'(((r + 1 + int'($urandom % (NROW - 1))) % NROW) * 2 + k % 2);
      put_row(r, k % 5 == 0);
      @(negedge clk);
    end
    wr_en = 1'b0;
    for (int p = 0; p < 2 * NROW; p++) begin
      rd_pc = PW'(p);
      @(negedge clk);
    end
    chk_en = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule